// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Array

This block gives a host up to 24 general-purpose pins through a byte-wide register bus. Pins are grouped in 8-bit banks. Each pin has an output latch that is changed through separate write-one set and write-one clear registers, and a direction bit that decides whether the latch or the outside world drives the pin level. The pin level is always visible to the host through a monitor register, after a two-stage synchroniser.

Every pin can raise an interrupt on a rising edge, a falling edge or both. A detected edge sets the pin's bit in two status registers at once: an interrupt status register and an edge-detect register. Both are cleared by writing ones. The single active-high interrupt output is high while any status bit is set whose interrupt-enable bit is also set. Because an output pin's monitored level is its own latch, edges produced by software on output pins are detected as well.

Registers are reached as `address = 4*group + slot`. The edge-enable, interrupt-enable, status and edge-detect groups put the highest bank in slot 0. The other groups put bank 0 in slot 0. The bus is combinational on reads and takes writes on the clock edge where the write strobe is high.

Top module: `gpio_edge_expander`

## Requirements
- R1: Pin n sits in bank n/8 at bit n%8. Group codes are monitor 0, set 1, clear 2, direction 3, rise-enable 4, fall-enable 5, interrupt-enable 6, status 7, edge-detect 8, and a register lives at address 4*group+slot. Groups 4 to 8 map slot s to bank (NUM_BANKS-1-s). Groups 0 to 3 map slot s to bank s.
- R2: A write to the set group makes 1 every latch bit written as 1. A write to the clear group makes 0 every latch bit written as 1. Bits written as 0 keep their value. Reading either group returns the latch, and `pin_out` always equals the latch.
- R3: A direction bit of 1 makes the pin an output and 0 an input. `pin_oe` equals the direction bits.
- R4: A monitor read returns, for each pin, the level after two clock stages. That level is the latch for an output pin and `pin_in` for an input pin.
- R5: Rise-enable and fall-enable are independent per pin. A pin with both enables set reacts to either edge, and a pin with neither set reacts to no edge. An edge is a change of the synchronised level between consecutive cycles.
- R6: An enabled edge sets the pin's bit in both the status and the edge-detect registers, one cycle after the synchronised level changes. No bit is ever set without such an edge.
- R7: `irq` is 1 exactly when some pin has both its status bit and its interrupt-enable bit set.
- R8: Writing a byte to the status or edge-detect group clears the bits written as 1 and leaves the bits written as 0 unchanged. Each of the two groups is cleared independently of the other.
- R9: When an enabled edge and a clearing write reach the same bit in the same cycle, the bit stays set.
- R10: Pins at or above NUM_PINS read 0 and ignore writes. A slot at or above NUM_BANKS, or a group code above 8, reads 0 and ignores writes. `bus_rdata` is 0 while `bus_rd` is low.
- R11: After reset every latch, direction, enable, status and edge-detect bit is 0, so all pins are inputs and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address (4*group + slot) |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_rd | input | 1 | Read enable; read data is combinational |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| pin_in | input | NUM_PINS | Levels seen at the pins |
| pin_out | output | NUM_PINS | Output latch driven toward the pins |
| pin_oe | output | NUM_PINS | Per-pin output enable (direction) |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with NUM_PINS set to 20. This leaves the top bank half populated, so the masking of absent pins in reads, writes, edge detection and `pin_out` can all be checked against a real partial bank. The default synchroniser depth of two is kept, which lets the reference model line up edge timing cycle by cycle. With three banks present, slot-to-bank reversal in the high groups is visible: slot 0 and slot 2 refer to different, distinguishable banks.

// File: rtl/gpio_xp_pkg.sv
package gpio_xp_pkg;

   localparam int BANK_W     = 8;
   localparam int MAX_PINS   = 24;
   localparam int GRP_STRIDE = 4;

   typedef enum logic [3:0] {
      GRP_MON  = 4'd0,
      GRP_SET  = 4'd1,
      GRP_CLR  = 4'd2,
      GRP_DIR  = 4'd3,
      GRP_RISE = 4'd4,
      GRP_FALL = 4'd5,
      GRP_IEN  = 4'd6,
      GRP_STAT = 4'd7,
      GRP_EDET = 4'd8
   } reg_grp_e;

   localparam int GRP_LAST = int'(GRP_EDET);

   // one write strobe per writable register of a bank
   typedef struct packed {
      logic set;
      logic clr;
      logic dir;
      logic rise;
      logic fall;
      logic ien;
      logic stat;
      logic edet;
   } bank_wr_t;

   // everything a bank can show on the read path
   typedef struct packed {
      logic [BANK_W-1:0] mon;
      logic [BANK_W-1:0] latch;
      logic [BANK_W-1:0] dir;
      logic [BANK_W-1:0] rise;
      logic [BANK_W-1:0] fall;
      logic [BANK_W-1:0] ien;
      logic [BANK_W-1:0] stat;
      logic [BANK_W-1:0] edet;
   } bank_view_t;

   // groups from rise-enable upward place the top bank in slot 0
   function automatic logic grp_msb_first(input int unsigned grp);
      return grp >= int'(GRP_RISE);
   endfunction

endpackage

// File: rtl/gpio_xp_sync.sv
module gpio_xp_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("gpio_xp_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_xp_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_xp_bank.sv
module gpio_xp_bank
   import gpio_xp_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [BANK_W-1:0] PIN_MASK    = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] pin_in,
   input  logic [BANK_W-1:0] wdata,
   input  bank_wr_t          i_wr,
   output logic [BANK_W-1:0] pin_out,
   output logic [BANK_W-1:0] pin_oe,
   output bank_view_t        view_o,
   output logic              irq_o
);

   logic [BANK_W-1:0] latch_q, dir_q, rise_q, fall_q, ien_q, stat_q, edet_q;
   logic [BANK_W-1:0] prev_q;
   logic [BANK_W-1:0] level, pad_level, edge_hit, wmask;
   logic [BANK_W-1:0] stat_wipe, edet_wipe;

   // output pins are observed through their own latch
   assign pad_level = ((dir_q & latch_q) | (~dir_q & pin_in)) & PIN_MASK;

   gpio_xp_sync #(
      .WIDTH  (BANK_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_level),
      .q_o   (level)
   );

   assign edge_hit  = PIN_MASK & ((rise_q & level & ~prev_q) |
                                  (fall_q & ~level & prev_q));
   assign wmask     = wdata & PIN_MASK;
   assign stat_wipe = i_wr.stat ? wmask : '0;
   assign edet_wipe = i_wr.edet ? wmask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         rise_q  <= '0;
         fall_q  <= '0;
         ien_q   <= '0;
         stat_q  <= '0;
         edet_q  <= '0;
         prev_q  <= '0;
      end else begin
         if (i_wr.set) begin
            latch_q <= latch_q | wmask;
         end else if (i_wr.clr) begin
            latch_q <= latch_q & ~wmask;
         end
         if (i_wr.dir)  dir_q  <= wmask;
         if (i_wr.rise) rise_q <= wmask;
         if (i_wr.fall) fall_q <= wmask;
         if (i_wr.ien)  ien_q  <= wmask;
         // a fresh edge is OR-ed after the wipe, so it survives a clear
         stat_q <= (stat_q & ~stat_wipe) | edge_hit;
         edet_q <= (edet_q & ~edet_wipe) | edge_hit;
         prev_q <= level;
      end
   end

   assign pin_out = latch_q;
   assign pin_oe  = dir_q;
   assign irq_o   = |(stat_q & ien_q);

   always_comb begin
      view_o       = '0;
      view_o.mon   = level;
      view_o.latch = latch_q;
      view_o.dir   = dir_q;
      view_o.rise  = rise_q;
      view_o.fall  = fall_q;
      view_o.ien   = ien_q;
      view_o.stat  = stat_q;
      view_o.edet  = edet_q;
   end

   // R2: set writes raise exactly the written bits
   p_set_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      i_wr.set |=> ((latch_q & $past(wmask)) == $past(wmask)));

   // R2: clear writes drop exactly the written bits
   p_clr_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (i_wr.clr && !i_wr.set) |=> ((latch_q & $past(wmask)) == '0));

   // R6: an enabled edge lands in both status copies
   p_edge_sets_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit != '0) |=> (((stat_q & edet_q) & $past(edge_hit)) == $past(edge_hit)));

   // R6: status never rises without an edge
   p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~$past(stat_q) & ~$past(edge_hit)) == '0));

   // R8: cleared bits with no new edge read back as 0
   p_stat_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      i_wr.stat |=> ((stat_q & $past(wmask & ~edge_hit)) == '0));

   // R9: a coincident edge beats the clear
   p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (i_wr.stat && ((edge_hit & wmask) != '0)) |=>
         ((stat_q & $past(edge_hit & wmask)) == $past(edge_hit & wmask)));

   // R10: absent pins never hold state
   p_absent_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (((latch_q | dir_q | stat_q | edet_q | ien_q) & ~PIN_MASK) == '0));

endmodule

// File: rtl/gpio_xp_regif.sv
module gpio_xp_regif
   import gpio_xp_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int ADDR_W    = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        wr_en,
   input  logic                        rd_en,
   input  bank_view_t [NUM_BANKS-1:0]  view_i,
   output bank_wr_t   [NUM_BANKS-1:0]  wr_o,
   output logic       [BANK_W-1:0]     rdata_o
);

   localparam int GRP_W = ADDR_W - 2;

   logic [GRP_W-1:0] grp_f;
   logic [1:0]       slot_f;
   int unsigned      grp_i;
   int unsigned      slot_i;
   int unsigned      bank_i;
   logic             target_ok;

   assign {grp_f, slot_f} = addr;

   always_comb begin
      grp_i     = 32'(grp_f);
      slot_i    = 32'(slot_f);
      target_ok = (grp_i <= GRP_LAST) && (slot_i < NUM_BANKS);
      if (grp_msb_first(grp_i)) begin
         bank_i = NUM_BANKS - 1 - slot_i;
      end else begin
         bank_i = slot_i;
      end
   end

   always_comb begin
      wr_o = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (wr_en && target_ok && (bank_i == b)) begin
            case (grp_i)
               int'(GRP_SET):  wr_o[b].set  = 1'b1;
               int'(GRP_CLR):  wr_o[b].clr  = 1'b1;
               int'(GRP_DIR):  wr_o[b].dir  = 1'b1;
               int'(GRP_RISE): wr_o[b].rise = 1'b1;
               int'(GRP_FALL): wr_o[b].fall = 1'b1;
               int'(GRP_IEN):  wr_o[b].ien  = 1'b1;
               int'(GRP_STAT): wr_o[b].stat = 1'b1;
               int'(GRP_EDET): wr_o[b].edet = 1'b1;
               default:        ;
            endcase
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_en && target_ok && (bank_i == b)) begin
            case (grp_i)
               int'(GRP_MON):  rdata_o = view_i[b].mon;
               int'(GRP_SET),
               int'(GRP_CLR):  rdata_o = view_i[b].latch;
               int'(GRP_DIR):  rdata_o = view_i[b].dir;
               int'(GRP_RISE): rdata_o = view_i[b].rise;
               int'(GRP_FALL): rdata_o = view_i[b].fall;
               int'(GRP_IEN):  rdata_o = view_i[b].ien;
               int'(GRP_STAT): rdata_o = view_i[b].stat;
               int'(GRP_EDET): rdata_o = view_i[b].edet;
               default:        rdata_o = '0;
            endcase
         end
      end
   end

   // R1: one address reaches at most one register
   p_single_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_o));

endmodule

// File: rtl/gpio_edge_expander.sv
module gpio_edge_expander
   import gpio_xp_pkg::*;
#(
   parameter int NUM_PINS    = 24,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [7:0]          bus_wdata,
   input  logic                bus_wr,
   input  logic                bus_rd,
   output logic [7:0]          bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);

   localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
   localparam int PAD_W     = NUM_BANKS * BANK_W;

   generate
      if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
         $error("gpio_edge_expander: NUM_PINS out of range 1..24");
      end
      if (ADDR_W < 6 || ADDR_W > 16) begin : g_bad_addr
         $error("gpio_edge_expander: ADDR_W must be 6..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_edge_expander: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PAD_W-1:0]           pin_in_pad, pin_out_pad, pin_oe_pad;
   bank_wr_t   [NUM_BANKS-1:0] bank_wr;
   bank_view_t [NUM_BANKS-1:0] bank_view;
   logic       [NUM_BANKS-1:0] bank_irq;
   logic                       ien_any;

   assign pin_in_pad = PAD_W'(pin_in);

   gpio_xp_regif #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W)
   ) u_regif (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .wr_en   (bus_wr),
      .rd_en   (bus_rd),
      .view_i  (bank_view),
      .wr_o    (bank_wr),
      .rdata_o (bus_rdata)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int PINS_HERE = ((NUM_PINS - b * BANK_W) >= BANK_W) ?
                                 BANK_W : (NUM_PINS - b * BANK_W);
      localparam logic [BANK_W-1:0] MASK_HERE = BANK_W'((1 << PINS_HERE) - 1);

      gpio_xp_bank #(
         .SYNC_STAGES (SYNC_STAGES),
         .PIN_MASK    (MASK_HERE)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_in  (pin_in_pad[b*BANK_W +: BANK_W]),
         .wdata   (bus_wdata),
         .i_wr    (bank_wr[b]),
         .pin_out (pin_out_pad[b*BANK_W +: BANK_W]),
         .pin_oe  (pin_oe_pad[b*BANK_W +: BANK_W]),
         .view_o  (bank_view[b]),
         .irq_o   (bank_irq[b])
      );
   end

   assign pin_out = pin_out_pad[NUM_PINS-1:0];
   assign pin_oe  = pin_oe_pad[NUM_PINS-1:0];
   assign irq     = |bank_irq;

   always_comb begin
      ien_any = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         ien_any = ien_any | (|bank_view[b].ien);
      end
   end

   // R7: the interrupt needs at least one enabled pin
   p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ien_any);

   generate
      if (PAD_W > NUM_PINS) begin : g_pad_check
         // R10: padding pins of a partial bank stay undriven
         p_pad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ((pin_out_pad[PAD_W-1:NUM_PINS] | pin_oe_pad[PAD_W-1:NUM_PINS]) == '0));
      end
   endgenerate

endmodule

// File: tb/test_gpio_edge_expander.sv
`timescale 1ns/1ps
module test_gpio_edge_expander;

   localparam int          NP    = 20;
   localparam int          AW    = 6;
   localparam logic [23:0] PMASK = 24'h0F_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0]    bus_wdata = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;
   logic          irq;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string phase = "R11";

   always #2.5 clk = ~clk;

   gpio_edge_expander #(
      .NUM_PINS    (NP),
      .ADDR_W      (AW),
      .SYNC_STAGES (2)
   ) i_gpio_edge_expander (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   // ---------------- reference model ----------------
   logic [23:0] m_latch, m_dir, m_rise, m_fall, m_ien, m_stat, m_edet;
   logic [23:0] hist[$];

   initial begin
      m_latch = '0; m_dir = '0; m_rise = '0; m_fall = '0;
      m_ien = '0; m_stat = '0; m_edet = '0;
      hist = '{24'h0, 24'h0, 24'h0};
   end

   function automatic int bank_of(input int g, input int s);
      return (g >= 4) ? (2 - s) : s;
   endfunction

   function automatic logic [7:0] m_read(input int a);
      int g;
      int s;
      logic [23:0] v;
      g = a / 4;
      s = a % 4;
      if (g > 8 || s >= 3) return 8'h00;
      case (g)
         0:       v = hist[1];
         1, 2:    v = m_latch;
         3:       v = m_dir;
         4:       v = m_rise;
         5:       v = m_fall;
         6:       v = m_ien;
         7:       v = m_stat;
         default: v = m_edet;
      endcase
      return 8'(v >> (8 * bank_of(g, s)));
   endfunction

   function automatic string req_of(input int g);
      case (g)
         0:       return "R4";
         1, 2:    return "R2";
         3:       return "R3";
         4, 5:    return "R5";
         6:       return "R7";
         7, 8:    return "R6";
         default: return "R10";
      endcase
   endfunction

   always @(posedge clk) begin : model_step
      logic [23:0] lvl, prv, eff, hit, sh, bmask, st_wipe, ed_wipe;
      int g, s;
      if (!rst_n) begin
         m_latch = '0; m_dir = '0; m_rise = '0; m_fall = '0;
         m_ien = '0; m_stat = '0; m_edet = '0;
         hist = '{24'h0, 24'h0, 24'h0};
      end else begin
         lvl = hist[1];
         prv = hist[2];
         hit = ((m_rise & lvl & ~prv) | (m_fall & ~lvl & prv)) & PMASK;
         eff = ((m_dir & m_latch) | (~m_dir & {4'h0, pin_in})) & PMASK;
         st_wipe = '0;
         ed_wipe = '0;
         if (bus_wr) begin
            g = int'(bus_addr) / 4;
            s = int'(bus_addr) % 4;
            if (g <= 8 && s < 3) begin
               sh    = (24'(bus_wdata) << (8 * bank_of(g, s))) & PMASK;
               bmask = 24'hFF << (8 * bank_of(g, s));
               case (g)
                  1: m_latch = m_latch | sh;
                  2: m_latch = m_latch & ~sh;
                  3: m_dir   = (m_dir  & ~bmask) | sh;
                  4: m_rise  = (m_rise & ~bmask) | sh;
                  5: m_fall  = (m_fall & ~bmask) | sh;
                  6: m_ien   = (m_ien  & ~bmask) | sh;
                  7: st_wipe = sh;
                  8: ed_wipe = sh;
                  default: ;
               endcase
            end
         end
         m_stat = (m_stat & ~st_wipe) | hit;
         m_edet = (m_edet & ~ed_wipe) | hit;
         hist.push_front(eff);
         void'(hist.pop_back());
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (phase %s) actual=%0h expected=%0h", tag, phase, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 pin_out", 32'(pin_out), 32'(m_latch & PMASK));
         chk("R3 pin_oe", 32'(pin_oe), 32'(m_dir & PMASK));
         chk("R7 irq", 32'(irq), 32'(|(m_stat & m_ien)));
         if (bus_rd) begin
            chk({req_of(int'(bus_addr) / 4), " rdata"}, 32'(bus_rdata),
                32'(m_read(int'(bus_addr))));
         end else begin
            chk("R10 idle rdata", 32'(bus_rdata), 32'h0);
         end
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr_reg(input int a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
      @(posedge clk); #1;
      bus_addr = AW'(a); bus_rd = 1'b1;
      @(negedge clk);
      chk({tag, " read"}, 32'(bus_rdata), 32'(exp));
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic set_pins(input logic [NP-1:0] v);
      @(posedge clk); #1;
      pin_in = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic chk_at_neg(input string tag, input logic [31:0] act_sel, input logic [31:0] exp);
      @(negedge clk);
      chk(tag, act_sel, exp);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // ---------------- sequence ----------------
   initial begin
      // R11: state while held in reset
      repeat (3) @(negedge clk);
      chk("R11 pin_oe in reset", 32'(pin_oe), 32'h0);
      chk("R11 pin_out in reset", 32'(pin_out), 32'h0);
      chk("R11 irq in reset", 32'(irq), 32'h0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      for (int a = 0; a < 64; a++) rd_chk(a, 8'h00, "R11");

      // R2: set then clear on bank 0
      phase = "R2";
      wr_reg(4, 8'hA5);
      wr_reg(8, 8'h21);
      rd_chk(4, 8'h84, "R2");
      rd_chk(8, 8'h84, "R2");
      @(negedge clk);
      chk("R2 pin_out bank0", 32'(pin_out[7:0]), 32'h84);

      // R3: bank 1 high nibble as outputs
      phase = "R3";
      wr_reg(13, 8'hF0);
      rd_chk(13, 8'hF0, "R3");
      @(negedge clk);
      chk("R3 pin_oe", 32'(pin_oe), 32'h0F000);

      // R4: monitor mixes driven latch and input levels
      phase = "R4";
      wr_reg(5, 8'h30);
      set_pins(20'h000AC);
      idle(4);
      rd_chk(0, 8'hAC, "R4");
      rd_chk(1, 8'h30, "R4");

      // R5 / R6: pin0 rise, pin1 both, pin2 fall, pin3 none
      phase = "R5";
      wr_reg(18, 8'h03);
      wr_reg(22, 8'h06);
      set_pins(20'h000A3);
      idle(4);
      rd_chk(30, 8'h07, "R5");
      rd_chk(34, 8'h07, "R6");
      phase = "R8";
      wr_reg(30, 8'hFF);
      wr_reg(34, 8'hFF);
      rd_chk(30, 8'h00, "R8");
      rd_chk(34, 8'h00, "R8");
      phase = "R5";
      set_pins(20'h000AC);
      idle(4);
      rd_chk(30, 8'h02, "R5");
      rd_chk(34, 8'h02, "R6");

      // R7: interrupt follows enable
      phase = "R7";
      chk_at_neg("R7 irq masked", 32'(irq), 32'h0);
      wr_reg(26, 8'h02);
      chk_at_neg("R7 irq enabled", 32'(irq), 32'h1);
      wr_reg(26, 8'h01);
      chk_at_neg("R7 irq other pin", 32'(irq), 32'h0);

      // R8: partial clear, independent copies
      phase = "R8";
      set_pins(20'h000A3);
      idle(4);
      chk_at_neg("R7 irq pin0", 32'(irq), 32'h1);
      wr_reg(30, 8'h01);
      rd_chk(30, 8'h06, "R8");
      rd_chk(34, 8'h07, "R8");
      chk_at_neg("R7 irq after clear", 32'(irq), 32'h0);

      // R9: falling edge on pin1 meets a clear of pin1
      phase = "R9";
      set_pins(20'h000A1);
      @(posedge clk);
      @(posedge clk); #1;
      bus_addr = AW'(30); bus_wdata = 8'h02; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      idle(2);
      rd_chk(30, 8'h06, "R9");
      phase = "R8";
      wr_reg(30, 8'h02);
      rd_chk(30, 8'h04, "R8");

      // R1: slot 0 of high groups is the top bank
      phase = "R1";
      wr_reg(16, 8'h01);
      set_pins(20'h100A1);
      idle(4);
      rd_chk(28, 8'h01, "R1");
      rd_chk(32, 8'h01, "R1");
      rd_chk(2, 8'h01, "R1");
      rd_chk(30, 8'h04, "R1");
      wr_reg(24, 8'h01);
      chk_at_neg("R1 irq from top bank", 32'(irq), 32'h1);

      // R10: absent pins and holes in the map
      phase = "R10";
      wr_reg(6, 8'hFF);
      rd_chk(6, 8'h0F, "R10");
      chk_at_neg("R10 pin_out top", 32'(pin_out[19:16]), 32'hF);
      wr_reg(16, 8'hFF);
      rd_chk(16, 8'h0F, "R10");
      wr_reg(3, 8'hFF);
      wr_reg(11, 8'hFF);
      wr_reg(44, 8'hFF);
      rd_chk(3, 8'h00, "R10");
      rd_chk(4, 8'h84, "R10");
      rd_chk(40, 8'h00, "R10");
      rd_chk(63, 8'h00, "R10");
      chk_at_neg("R10 pin_out bank0 kept", 32'(pin_out[7:0]), 32'h84);

      idle(2);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog (phase %s) actual=running expected=finished", phase);
         summary();
         $finish;
      end
   end

endmodule